// File: doc/BRIEF.md
# Receive Status Flags and DMA Request Gating

This block sits behind the receive shift logic of a serial port and turns character-level events into sticky status and request outputs. Each time a character finishes, a one-cycle strobe arrives together with three error indications: framing, noise and parity. The block keeps these outputs:

- a data-ready flag;
- an overrun flag;
- one sticky flag per error kind.

From that state it derives the DMA receive request and the error interrupt. Software clears each flag with its own one-cycle pulse. A data-read strobe marks the held character as consumed.

A policy input selects what happens to a character that arrives with an error:

- **Hide policy:** the character is hidden from DMA. Its error flag is set, but data-ready is not raised for it, so no request is made. The next clean character is delivered normally.
- **Halt policy:** the character raises both its error flag and data-ready. The DMA request is then held off until software clears every error flag.

A separate input turns overrun detection off. With detection off, a new character silently replaces an unread one.

Top module: `rx_err_gate`

## Requirements
- R1: While and after reset, data_rdy, ovr_flag, every err_flag bit, dma_req and err_irq are 0.
- R2: Error flag bits are bit 0 framing, bit 1 noise, bit 2 parity. Flag bit i becomes 1 at the clock edge where char_done=1 and err_in[i]=1. Once set, the bit stays 1 until an edge where err_clr[i]=1 and no new error of that kind arrives; if both happen at one edge, the flag stays 1.
- R3: ovr_flag becomes 1 at an edge where char_done=1, data_rdy=1, rd_stb=0 and cfg_ovr_off=0. It stays 1 until an edge with ovr_clr=1 and no new overrun; if both happen at one edge, the flag stays 1.
- R4: With cfg_ovr_off=1, a character arriving while data_rdy=1 raises no overrun flag, and data_rdy stays 1.
- R5: With cfg_halt_on_err=0, a character with any err_in bit set does not set data_rdy; a character with no error bit set does set it.
- R6: With cfg_halt_on_err=1, a character with an error sets data_rdy and its error flag. dma_req stays 0 while any err_flag bit is 1.
- R7: dma_req is 1 exactly when all three hold: data_rdy=1, cfg_dma_en=1, and not (cfg_halt_on_err=1 with any err_flag bit set). It is always 0 while cfg_dma_en=0.
- R8: rd_stb clears data_rdy at the next edge, unless a character that sets data_rdy completes in that same cycle, in which case data_rdy stays 1.
- R9: err_irq is 1 exactly when cfg_irq_en=1 and at least one of these flags is set: framing (bit 0), noise (bit 1) or ovr_flag. A parity flag alone does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_done | input | 1 | One-cycle strobe: a received character has completed |
| err_in | input | 3 | Error indications for the completing character (0 framing, 1 noise, 2 parity) |
| rd_stb | input | 1 | Data-read strobe: the held character has been consumed |
| err_clr | input | 3 | Software clear pulses, one per error flag |
| ovr_clr | input | 1 | Software clear pulse for the overrun flag |
| cfg_ovr_off | input | 1 | 1 disables overrun detection |
| cfg_halt_on_err | input | 1 | 1 selects the halt policy, 0 the hide policy |
| cfg_dma_en | input | 1 | Enables the DMA receive request |
| cfg_irq_en | input | 1 | Enables the error interrupt |
| data_rdy | output | 1 | A received character is waiting to be read |
| ovr_flag | output | 1 | Sticky overrun flag |
| err_flag | output | 3 | Sticky error flags (0 framing, 1 noise, 2 parity) |
| dma_req | output | 1 | DMA receive request |
| err_irq | output | 1 | Error interrupt |

## Verification
The assertions assume that char_done, rd_stb and the clear inputs are sampled only at clock edges. They also assume that err_in has meaning only in a cycle where char_done is 1. No stimulus-order assumption is made between these inputs: same-edge collisions are legal and are checked.

The bench sweeps all sixteen combinations of the four configuration inputs. Under each combination it drives a pseudo-random mix of characters, errors, reads and clears. The generated mix deliberately includes same-cycle read-versus-character and set-versus-clear collisions. All inputs change only on the falling edge, so every sampled value is settled.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
    // Number of per-character error kinds and their bit positions.
    localparam int unsigned NUM_ERR = 3;
    localparam int unsigned ERR_FRM = 0;
    localparam int unsigned ERR_NSE = 1;
    localparam int unsigned ERR_PAR = 2;

    // Error kinds that feed the error interrupt (framing and noise).
    localparam logic [NUM_ERR-1:0] IRQ_ERR_MASK = NUM_ERR'((1 << ERR_FRM) | (1 << ERR_NSE));

    // Receive-holding state.
    typedef struct packed {
        logic rdy;
        logic ovr;
    } rdy_state_t;
endpackage

// File: rtl/rx_err_flags.sv
module rx_err_flags #(
    parameter int unsigned N = rx_err_pkg::NUM_ERR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         char_done,
    input  logic [N-1:0] err_in,
    input  logic [N-1:0] err_clr,
    output logic [N-1:0] flag
);
    logic [N-1:0] flag_d, flag_q;

    // Sticky flags: a new error wins over a clear at the same edge.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            flag_d[i] = (char_done & err_in[i]) | (flag_q[i] & ~err_clr[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/rx_ready_ctl.sv
module rx_ready_ctl
    import rx_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic char_done,
    input  logic char_bad,
    input  logic rd_stb,
    input  logic ovr_clr,
    input  logic cfg_ovr_off,
    input  logic cfg_halt_on_err,
    output logic data_rdy,
    output logic ovr_flag
);
    rdy_state_t st_d, st_q;
    logic accept;
    logic unread;
    logic ovr_hit;

    always_comb begin
        // A bad character is made visible only under the halt policy.
        accept  = char_done & (cfg_halt_on_err | ~char_bad);
        // A character read in this very cycle no longer counts as unread.
        unread  = st_q.rdy & ~rd_stb;
        ovr_hit = char_done & unread & ~cfg_ovr_off;

        st_d = st_q;
        st_d.ovr = ovr_hit | (st_q.ovr & ~ovr_clr);
        if (accept)      st_d.rdy = 1'b1;
        else if (rd_stb) st_d.rdy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_rdy = st_q.rdy;
    assign ovr_flag = st_q.ovr;
endmodule

// File: rtl/rx_req_gate.sv
module rx_req_gate #(
    parameter int unsigned         N        = rx_err_pkg::NUM_ERR,
    parameter logic [N-1:0]        IRQ_MASK = rx_err_pkg::IRQ_ERR_MASK
) (
    input  logic         data_rdy,
    input  logic         ovr_flag,
    input  logic [N-1:0] err_flag,
    input  logic         cfg_dma_en,
    input  logic         cfg_halt_on_err,
    input  logic         cfg_irq_en,
    output logic         dma_req,
    output logic         err_irq
);
    logic any_err;
    logic dma_mask;
    logic irq_src;

    always_comb begin
        any_err  = |err_flag;
        dma_mask = cfg_halt_on_err & any_err;
        irq_src  = ovr_flag | (|(err_flag & IRQ_MASK));
        dma_req  = data_rdy & cfg_dma_en & ~dma_mask;
        err_irq  = cfg_irq_en & irq_src;
    end
endmodule

// File: rtl/rx_err_gate.sv
module rx_err_gate #(
    parameter int unsigned  N_ERR    = rx_err_pkg::NUM_ERR,
    parameter logic [N_ERR-1:0] IRQ_MASK = rx_err_pkg::IRQ_ERR_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_done,
    input  logic [N_ERR-1:0] err_in,
    input  logic             rd_stb,
    input  logic [N_ERR-1:0] err_clr,
    input  logic             ovr_clr,
    input  logic             cfg_ovr_off,
    input  logic             cfg_halt_on_err,
    input  logic             cfg_dma_en,
    input  logic             cfg_irq_en,
    output logic             data_rdy,
    output logic             ovr_flag,
    output logic [N_ERR-1:0] err_flag,
    output logic             dma_req,
    output logic             err_irq
);
    logic char_bad;

    assign char_bad = |err_in;

    rx_err_flags #(.N(N_ERR)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_done (char_done),
        .err_in    (err_in),
        .err_clr   (err_clr),
        .flag      (err_flag)
    );

    rx_ready_ctl u_ready (
        .clk             (clk),
        .rst_n           (rst_n),
        .char_done       (char_done),
        .char_bad        (char_bad),
        .rd_stb          (rd_stb),
        .ovr_clr         (ovr_clr),
        .cfg_ovr_off     (cfg_ovr_off),
        .cfg_halt_on_err (cfg_halt_on_err),
        .data_rdy        (data_rdy),
        .ovr_flag        (ovr_flag)
    );

    rx_req_gate #(.N(N_ERR), .IRQ_MASK(IRQ_MASK)) u_gate (
        .data_rdy        (data_rdy),
        .ovr_flag        (ovr_flag),
        .err_flag        (err_flag),
        .cfg_dma_en      (cfg_dma_en),
        .cfg_halt_on_err (cfg_halt_on_err),
        .cfg_irq_en      (cfg_irq_en),
        .dma_req         (dma_req),
        .err_irq         (err_irq)
    );
endmodule

// File: rtl/rx_err_gate_chk.sv
module rx_err_gate_chk #(
    parameter int unsigned N_ERR = rx_err_pkg::NUM_ERR
) (
    input logic             clk,
    input logic             rst_n,
    input logic             char_done,
    input logic [N_ERR-1:0] err_in,
    input logic             rd_stb,
    input logic [N_ERR-1:0] err_clr,
    input logic             ovr_clr,
    input logic             cfg_ovr_off,
    input logic             cfg_halt_on_err,
    input logic             cfg_dma_en,
    input logic             cfg_irq_en,
    input logic             data_rdy,
    input logic             ovr_flag,
    input logic [N_ERR-1:0] err_flag,
    input logic             dma_req,
    input logic             err_irq
);
    for (genvar i = 0; i < N_ERR; i++) begin : g_bit
        p_err_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (char_done && err_in[i]) |=> err_flag[i]);
        p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (err_flag[i] && !err_clr[i]) |=> err_flag[i]);
    end

    p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && data_rdy && !rd_stb && !cfg_ovr_off) |=> ovr_flag);

    p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    p_no_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_flag && cfg_ovr_off) |=> !ovr_flag);

    p_hide_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && (|err_in) && !cfg_halt_on_err && !data_rdy) |=> !data_rdy);

    p_halt_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_halt_on_err && (|err_flag)) |-> !dma_req);

    p_dma_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dma_en |-> !dma_req);

    p_req_needs_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> data_rdy);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !char_done) |=> !data_rdy);

    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !err_irq);

    p_irq_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_en && ovr_flag) |-> err_irq);
endmodule

bind rx_err_gate rx_err_gate_chk #(.N_ERR(N_ERR)) u_chk (.*);

// File: tb/rx_err_gate_test.sv
module rx_err_gate_test;
    localparam int unsigned NE = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic char_done, rd_stb, ovr_clr;
    logic [NE-1:0] err_in, err_clr;
    logic cfg_ovr_off, cfg_halt_on_err, cfg_dma_en, cfg_irq_en;
    logic data_rdy, ovr_flag, dma_req, err_irq;
    logic [NE-1:0] err_flag;

    int checks = 0;
    int failures = 0;

    // Bench expectation state, updated from the requirements.
    logic m_rdy, m_ovr;
    logic [NE-1:0] m_flag;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    rx_err_gate uut (
        .clk(clk), .rst_n(rst_n), .char_done(char_done), .err_in(err_in),
        .rd_stb(rd_stb), .err_clr(err_clr), .ovr_clr(ovr_clr),
        .cfg_ovr_off(cfg_ovr_off), .cfg_halt_on_err(cfg_halt_on_err),
        .cfg_dma_en(cfg_dma_en), .cfg_irq_en(cfg_irq_en),
        .data_rdy(data_rdy), .ovr_flag(ovr_flag), .err_flag(err_flag),
        .dma_req(dma_req), .err_irq(err_irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        char_done = 0; err_in = '0; rd_stb = 0; err_clr = '0; ovr_clr = 0;
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge.
    task automatic step();
        logic accept, ovr_hit;
        @(posedge clk);
        accept  = char_done & (cfg_halt_on_err | ~(|err_in));
        ovr_hit = char_done & m_rdy & ~rd_stb & ~cfg_ovr_off;
        m_ovr   = ovr_hit | (m_ovr & ~ovr_clr);
        m_flag  = (char_done ? err_in : '0) | (m_flag & ~err_clr);
        if (accept)      m_rdy = 1'b1;
        else if (rd_stb) m_rdy = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmp_all();
        chk("R8 data_rdy", int'(data_rdy), int'(m_rdy));
        chk("R3 ovr_flag", int'(ovr_flag), int'(m_ovr));
        chk("R2 err_flag", int'(err_flag), int'(m_flag));
        chk("R7 dma_req", int'(dma_req),
            int'(m_rdy & cfg_dma_en & ~(cfg_halt_on_err & (|m_flag))));
        chk("R9 err_irq", int'(err_irq),
            int'(cfg_irq_en & (m_flag[0] | m_flag[1] | m_ovr)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0; idle_inputs();
        cfg_ovr_off = 0; cfg_halt_on_err = 0; cfg_dma_en = 1; cfg_irq_en = 1;
        m_rdy = 0; m_ovr = 0; m_flag = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 data_rdy", int'(data_rdy), 0);
        chk("R1 ovr_flag", int'(ovr_flag), 0);
        chk("R1 err_flag", int'(err_flag), 0);
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 err_irq", int'(err_irq), 0);
        rst_n = 1;

        // R5: hide policy, parity-bad character stays hidden
        char_done = 1; err_in = 3'b100; step(); idle_inputs();
        chk("R5 rdy hidden", int'(data_rdy), 0);
        chk("R2 parity flag", int'(err_flag), 3'b100);
        chk("R9 parity alone no irq", int'(err_irq), 0);
        // clean character is delivered
        char_done = 1; step(); idle_inputs();
        chk("R5 clean rdy", int'(data_rdy), 1);
        chk("R7 req hide policy", int'(dma_req), 1);
        // R4: overrun disabled
        cfg_ovr_off = 1; char_done = 1; step(); idle_inputs();
        chk("R4 no ovr", int'(ovr_flag), 0);
        chk("R4 rdy kept", int'(data_rdy), 1);
        // R3: overrun enabled
        cfg_ovr_off = 0; char_done = 1; step(); idle_inputs();
        chk("R3 ovr set", int'(ovr_flag), 1);
        chk("R9 irq on ovr", int'(err_irq), 1);
        // R3 set-vs-clear: clear together with new overrun keeps flag
        char_done = 1; ovr_clr = 1; step(); idle_inputs();
        chk("R3 set wins", int'(ovr_flag), 1);
        ovr_clr = 1; step(); idle_inputs();
        chk("R3 cleared", int'(ovr_flag), 0);
        // R8: read clears
        rd_stb = 1; step(); idle_inputs();
        chk("R8 read clears", int'(data_rdy), 0);
        // R8: read and new character at once
        char_done = 1; step(); idle_inputs();
        rd_stb = 1; char_done = 1; step(); idle_inputs();
        chk("R8 new char wins", int'(data_rdy), 1);
        chk("R3 no ovr on same-cycle read", int'(ovr_flag), 0);
        rd_stb = 1; err_clr = 3'b111; step(); idle_inputs();
        // R6: halt policy
        cfg_halt_on_err = 1; char_done = 1; err_in = 3'b001; step(); idle_inputs();
        chk("R6 rdy set", int'(data_rdy), 1);
        chk("R6 frm flag", int'(err_flag), 3'b001);
        chk("R6 req masked", int'(dma_req), 0);
        // R2: set beats clear on the same edge
        char_done = 1; err_in = 3'b001; err_clr = 3'b001; step(); idle_inputs();
        chk("R2 set wins", int'(err_flag[0]), 1);
        err_clr = 3'b001; step(); idle_inputs();
        chk("R6 req after clear", int'(dma_req), 1);
        cfg_dma_en = 0; #1;
        chk("R7 dma disabled", int'(dma_req), 0);
        cfg_irq_en = 0; #1;
        chk("R9 irq disabled", int'(err_irq), 0);

        // Sweep over every configuration with pseudo-random traffic.
        for (int cfg = 0; cfg < 16; cfg++) begin
            {cfg_ovr_off, cfg_halt_on_err, cfg_dma_en, cfg_irq_en} = 4'(cfg);
            for (int n = 0; n < 300; n++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                char_done = lfsr[0] | lfsr[5];
                err_in    = {lfsr[1] & lfsr[7], lfsr[2] & lfsr[8], lfsr[3] & lfsr[9]};
                rd_stb    = lfsr[4] & lfsr[11];
                err_clr   = {lfsr[6] & lfsr[12], lfsr[13] & lfsr[10], lfsr[14] & lfsr[6]};
                ovr_clr   = lfsr[15] & lfsr[2];
                step();
                cmp_all();
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule